// File: doc/BRIEF.md
# Timer Run and External Interrupt Control Register

This block is a bit-addressable special-function register for an 8051-style core. It holds the run enables for two timers and latches each timer's overflow as an interrupt request. It also detects requests on two active-low external interrupt pins. For each pin, software chooses between falling-edge detection and low-level detection. The interrupt controller sends one acknowledge strobe per source when it vectors to the service routine.

The register answers byte reads and byte writes at one address. It also answers single-bit writes at the eight bit addresses that share that address's upper five bits, with bit n at the register address plus n. The timer counters, interrupt priority and vector generation are outside this block. The pin inputs are expected to be synchronized already.

Top module: `tmr_xint_ctl`

## Requirements
- R1: After reset, every register bit is 0, so `tmr_run`, `tmr_req` and `xreq` are all 0 and a read of the register returns 0x00.
- R2: A byte write with `sfr_addr` equal to the register address (0x88 by default) loads all eight bits one cycle later. The bit layout is: bit 7 timer 1 overflow flag, bit 6 timer 1 run, bit 5 timer 0 overflow flag, bit 4 timer 0 run, bit 3 pin 1 flag, bit 2 pin 1 mode, bit 1 pin 0 flag, bit 0 pin 0 mode. A byte write to any other address changes nothing.
- R3: A bit write to bit address 0x88+n, for n from 0 to 7, loads `bit_val` into bit n only. All other bits keep their values.
- R4: A run bit changes only through a software write. `tmr_run[i]` shows the stored run bit of timer i.
- R5: An overflow strobe on `tmr_ovf[i]` sets the timer's flag, and `tmr_req[i]` is 1 on the next cycle. An acknowledge on `tmr_ack[i]` clears the flag on the next cycle.
- R6: When a hardware set arrives in the same cycle as an acknowledge or a software write of the same flag, the flag ends up as 1.
- R7: With the mode bit at 1 (edge), a pin sampled low after being sampled high sets the flag on the next cycle. A pin that stays low does not set the flag again.
- R8: In edge mode, `xack[i]` clears the flag on the next cycle unless a new falling edge arrives in the same cycle.
- R9: With the mode bit at 0 (level), the flag bit and `xreq[i]` equal the inverted pin in the same cycle, and an acknowledge has no effect on them.
- R10: `sfr_rdata` returns the live register value, including level-mode flags, while `sfr_addr` equals the register address. It returns 0x00 for any other address.
- R11: In edge mode, a software write to a flag bit takes effect. In level mode the stored latch is held at 0, so a write to the flag bit has no visible effect, and a later switch to edge mode starts with the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | ADDR_W | Byte address for reads and byte writes |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_addr | input | ADDR_W | Bit address for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| tmr_ovf | input | 2 | Overflow strobe from each timer |
| tmr_ack | input | 2 | Vector acknowledge for each timer interrupt |
| xpin_n | input | 2 | Synchronized active-low external interrupt pins |
| xack | input | 2 | Vector acknowledge for each external interrupt |
| sfr_rdata | output | 8 | Read data |
| tmr_run | output | 2 | Timer run enables |
| tmr_req | output | 2 | Timer overflow requests |
| xreq | output | 2 | External interrupt requests |

## Verification
Directed sequences exercise the collisions that decide the flag priority: an overflow together with its acknowledge, and a falling edge together with an acknowledge or a flag write. They also cover a pin held low after its edge, which tells edge detection apart from level detection. Level mode is driven with pin toggles and acknowledges, which shows whether the flag follows the pin combinationally or keeps a latched value. Random traffic then mixes byte writes, bit writes, writes to foreign addresses, strobes and pin activity, and checks every cycle against a bench model. This exposes a wrong bit position, a write that reaches the wrong bit, or a priority that drops an event.

// File: rtl/tmr_xint_pkg.sv
package tmr_xint_pkg;

    localparam int unsigned NCH    = 2;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned BIDX_W = $clog2(REG_W);

    typedef enum logic {
        DET_LEVEL = 1'b0,
        DET_FALL  = 1'b1
    } det_mode_e;

    typedef struct packed {
        logic set;
        logic wr_en;
        logic wr_val;
        logic clr;
    } flag_ctl_t;

    // bit positions inside the register, per channel
    function automatic int unsigned pos_xmode(input int unsigned ch);
        return 2 * ch;
    endfunction

    function automatic int unsigned pos_xflag(input int unsigned ch);
        return 2 * ch + 1;
    endfunction

    function automatic int unsigned pos_run(input int unsigned ch);
        return 2 * NCH + 2 * ch;
    endfunction

    function automatic int unsigned pos_ovf(input int unsigned ch);
        return 2 * NCH + 2 * ch + 1;
    endfunction

    // hardware set beats software write beats acknowledge clear
    function automatic logic flag_next(input logic cur, input flag_ctl_t c);
        if (c.set)
            return 1'b1;
        else if (c.wr_en)
            return c.wr_val;
        else if (c.clr)
            return 1'b0;
        return cur;
    endfunction

endpackage

// File: rtl/tmr_xint_wrdec.sv
module tmr_xint_wrdec
    import tmr_xint_pkg::*;
#(
    parameter int unsigned         ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]   REG_ADDR = 'h88
) (
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [REG_W-1:0]  sfr_wdata,
    input  logic              bit_wr,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic              bit_val,
    output logic [REG_W-1:0]  wr_en,
    output logic [REG_W-1:0]  wr_val
);

    logic byte_hit;
    logic bit_hit;

    assign byte_hit = sfr_wr && (sfr_addr == REG_ADDR);
    assign bit_hit  = bit_wr && (bit_addr[ADDR_W-1:BIDX_W] == REG_ADDR[ADDR_W-1:BIDX_W]);

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        assign wr_en[b]  = byte_hit || (bit_hit && (bit_addr[BIDX_W-1:0] == BIDX_W'(b)));
        assign wr_val[b] = byte_hit ? sfr_wdata[b] : bit_val;
    end

endmodule

// File: rtl/tmr_xint_tmrch.sv
module tmr_xint_tmrch
    import tmr_xint_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ovf_stb,
    input  logic ack,
    input  logic run_we,
    input  logic run_wv,
    input  logic flag_we,
    input  logic flag_wv,
    output logic run,
    output logic flag
);

    logic      run_q;
    logic      flag_q;
    flag_ctl_t ctl;

    always_comb begin
        ctl.set    = ovf_stb;
        ctl.wr_en  = flag_we;
        ctl.wr_val = flag_wv;
        ctl.clr    = ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (run_we)
                run_q <= run_wv;
            flag_q <= flag_next(flag_q, ctl);
        end
    end

    assign run  = run_q;
    assign flag = flag_q;

endmodule

// File: rtl/tmr_xint_extch.sv
module tmr_xint_extch
    import tmr_xint_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic ack,
    input  logic mode_we,
    input  logic mode_wv,
    input  logic flag_we,
    input  logic flag_wv,
    output logic mode,
    output logic flag
);

    det_mode_e mode_q;
    logic      prev_q;
    logic      latch_q;
    logic      fall;
    flag_ctl_t ctl;

    assign fall = prev_q & ~pin_n;

    always_comb begin
        ctl.set    = fall;
        ctl.wr_en  = flag_we;
        ctl.wr_val = flag_wv;
        ctl.clr    = ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= DET_LEVEL;
            prev_q  <= 1'b1;
            latch_q <= 1'b0;
        end else begin
            prev_q <= pin_n;
            if (mode_we)
                mode_q <= det_mode_e'(mode_wv);
            if (mode_q == DET_FALL)
                latch_q <= flag_next(latch_q, ctl);
            else
                latch_q <= 1'b0;
        end
    end

    assign mode = (mode_q == DET_FALL);
    assign flag = (mode_q == DET_FALL) ? latch_q : ~pin_n;

endmodule

// File: rtl/tmr_xint_ctl.sv
module tmr_xint_ctl
    import tmr_xint_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h88
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [7:0]        sfr_wdata,
    input  logic              bit_wr,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic              bit_val,
    input  logic [1:0]        tmr_ovf,
    input  logic [1:0]        tmr_ack,
    input  logic [1:0]        xpin_n,
    input  logic [1:0]        xack,
    output logic [7:0]        sfr_rdata,
    output logic [1:0]        tmr_run,
    output logic [1:0]        tmr_req,
    output logic [1:0]        xreq
);

    logic [REG_W-1:0] wr_en;
    logic [REG_W-1:0] wr_val;
    logic [REG_W-1:0] live;
    logic [NCH-1:0]   xmode_q;

    tmr_xint_wrdec #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_wrdec (
        .sfr_addr  (sfr_addr),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .bit_wr    (bit_wr),
        .bit_addr  (bit_addr),
        .bit_val   (bit_val),
        .wr_en     (wr_en),
        .wr_val    (wr_val)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int unsigned P_RUN = pos_run(c);
        localparam int unsigned P_OVF = pos_ovf(c);
        localparam int unsigned P_XM  = pos_xmode(c);
        localparam int unsigned P_XF  = pos_xflag(c);

        tmr_xint_tmrch u_tmr (
            .clk     (clk),
            .rst     (rst),
            .ovf_stb (tmr_ovf[c]),
            .ack     (tmr_ack[c]),
            .run_we  (wr_en[P_RUN]),
            .run_wv  (wr_val[P_RUN]),
            .flag_we (wr_en[P_OVF]),
            .flag_wv (wr_val[P_OVF]),
            .run     (tmr_run[c]),
            .flag    (tmr_req[c])
        );

        tmr_xint_extch u_ext (
            .clk     (clk),
            .rst     (rst),
            .pin_n   (xpin_n[c]),
            .ack     (xack[c]),
            .mode_we (wr_en[P_XM]),
            .mode_wv (wr_val[P_XM]),
            .flag_we (wr_en[P_XF]),
            .flag_wv (wr_val[P_XF]),
            .mode    (xmode_q[c]),
            .flag    (xreq[c])
        );

        assign live[P_RUN] = tmr_run[c];
        assign live[P_OVF] = tmr_req[c];
        assign live[P_XM]  = xmode_q[c];
        assign live[P_XF]  = xreq[c];
    end

    assign sfr_rdata = (sfr_addr == REG_ADDR) ? live : '0;

endmodule

// File: rtl/tmr_xint_chk.sv
module tmr_xint_chk #(
    parameter int unsigned       ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h88
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic              sfr_wr,
    input logic              bit_wr,
    input logic [7:0]        sfr_rdata,
    input logic [1:0]        tmr_ovf,
    input logic [1:0]        tmr_req,
    input logic [1:0]        tmr_run,
    input logic [1:0]        xpin_n,
    input logic [1:0]        xmode,
    input logic [1:0]        xreq
);

    AST_RDATA_MISS: assert property (@(posedge clk) disable iff (rst)
        (sfr_addr != REG_ADDR) |-> (sfr_rdata == 8'h00)); // R10

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sfr_wr && !bit_wr) |=> $stable(tmr_run)); // R4

    for (genvar c = 0; c < 2; c++) begin : g_c
        AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
            tmr_ovf[c] |=> tmr_req[c]); // R6

        AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
            !xmode[c] |-> (xreq[c] == !xpin_n[c])); // R9

        AST_EDGE_SET: assert property (@(posedge clk) disable iff (rst)
            (xmode[c] && !xpin_n[c] && $past(xpin_n[c])) |=> (xreq[c] || !xmode[c])); // R7
    end

endmodule

bind tmr_xint_ctl tmr_xint_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .bit_wr    (bit_wr),
    .sfr_rdata (sfr_rdata),
    .tmr_ovf   (tmr_ovf),
    .tmr_req   (tmr_req),
    .tmr_run   (tmr_run),
    .xpin_n    (xpin_n),
    .xmode     (xmode_q),
    .xreq      (xreq)
);

// File: tb/tmr_xint_ctl_test.sv
module tmr_xint_ctl_test;

    localparam int PERIOD = 10;
    localparam logic [7:0] RA = 8'h88;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sfr_addr = RA;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = '0;
    logic       bit_wr = 1'b0;
    logic [7:0] bit_addr = '0;
    logic       bit_val = 1'b0;
    logic [1:0] tmr_ovf = '0;
    logic [1:0] tmr_ack = '0;
    logic [1:0] xpin_n = 2'b11;
    logic [1:0] xack = '0;
    logic [7:0] sfr_rdata;
    logic [1:0] tmr_run, tmr_req, xreq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model
    logic [1:0] m_run = '0, m_tf = '0, m_xm = '0, m_xl = '0, m_prev = 2'b11;

    always #(PERIOD/2) clk = ~clk;

    tmr_xint_ctl uut (
        .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .bit_wr(bit_wr), .bit_addr(bit_addr), .bit_val(bit_val), .tmr_ovf(tmr_ovf),
        .tmr_ack(tmr_ack), .xpin_n(xpin_n), .xack(xack), .sfr_rdata(sfr_rdata),
        .tmr_run(tmr_run), .tmr_req(tmr_req), .xreq(xreq)
    );

    function automatic logic [1:0] exp_xreq();
        logic [1:0] r;
        for (int c = 0; c < 2; c++) r[c] = m_xm[c] ? m_xl[c] : ~xpin_n[c];
        return r;
    endfunction

    function automatic logic [7:0] exp_reg();
        logic [1:0] xr;
        xr = exp_xreq();
        return {m_tf[1], m_run[1], m_tf[0], m_run[0], xr[1], m_xm[1], xr[0], m_xm[0]};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        sfr_wr = 0; bit_wr = 0; tmr_ovf = '0; tmr_ack = '0; xack = '0; sfr_addr = RA;
    endtask

    // inputs already driven after a negedge; advance one edge, update model, compare
    task automatic tick(input string tag);
        logic [7:0] we, wv;
        logic bh, bth;
        logic [1:0] n_run, n_tf, n_xm, n_xl;
        bh  = sfr_wr && (sfr_addr == RA);
        bth = bit_wr && (bit_addr[7:3] == RA[7:3]);
        for (int b = 0; b < 8; b++) begin
            we[b] = bh || (bth && bit_addr[2:0] == 3'(b));
            wv[b] = bh ? sfr_wdata[b] : bit_val;
        end
        for (int c = 0; c < 2; c++) begin
            n_run[c] = we[4+2*c] ? wv[4+2*c] : m_run[c];
            n_tf[c]  = tmr_ovf[c] ? 1'b1 : we[5+2*c] ? wv[5+2*c] : tmr_ack[c] ? 1'b0 : m_tf[c];
            n_xm[c]  = we[2*c] ? wv[2*c] : m_xm[c];
            if (!m_xm[c]) n_xl[c] = 1'b0;
            else n_xl[c] = (m_prev[c] && !xpin_n[c]) ? 1'b1 : we[2*c+1] ? wv[2*c+1] :
                           xack[c] ? 1'b0 : m_xl[c];
        end
        @(posedge clk);
        #1;
        m_run = n_run; m_tf = n_tf; m_xm = n_xm; m_xl = n_xl; m_prev = xpin_n;
        chk(tag, sfr_rdata, (sfr_addr == RA) ? exp_reg() : 8'h00);
        chk("R4 run", {6'b0, tmr_run}, {6'b0, m_run});
        chk("R5 timer flag", {6'b0, tmr_req}, {6'b0, m_tf});
        chk("R7 R9 pin flag", {6'b0, xreq}, {6'b0, exp_xreq()});
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;
        chk("R1 reset read", sfr_rdata, 8'h00);
        chk("R1 reset outs", {tmr_run, tmr_req, xreq, 2'b00}, 8'h00);

        // R2 byte write
        @(negedge clk); idle(); sfr_wr = 1; sfr_wdata = 8'h55; tick("R2");
        chk("R2 byte load", sfr_rdata, 8'h55);
        @(negedge clk); idle(); sfr_wr = 1; sfr_addr = 8'h89; sfr_wdata = 8'h00; tick("R10");
        @(negedge clk); idle(); tick("R2");
        chk("R2 other address ignored", sfr_rdata, 8'h55);

        // R3 bit write bit 6 -> 0
        @(negedge clk); idle(); bit_wr = 1; bit_addr = 8'h8E; bit_val = 0; tick("R3");
        chk("R3 single bit", sfr_rdata, 8'h15);

        // R6 overflow with ack together, then R5 ack
        @(negedge clk); idle(); tmr_ovf = 2'b01; tmr_ack = 2'b01; tick("R6");
        chk("R6 set beats ack", {6'b0, tmr_req}, 8'h01);
        @(negedge clk); idle(); tmr_ack = 2'b01; tick("R5");
        chk("R5 ack clears", {6'b0, tmr_req}, 8'h00);

        // R7 edge on pin 0 (mode 1 from 0x55)
        @(negedge clk); idle(); xpin_n = 2'b10; tick("R7");
        chk("R7 edge sets", {7'b0, xreq[0]}, 8'h01);
        @(negedge clk); idle(); xack = 2'b01; tick("R8");
        chk("R8 ack clears edge flag", {7'b0, xreq[0]}, 8'h00);
        @(negedge clk); idle(); tick("R7");
        chk("R7 held low no reset", {7'b0, xreq[0]}, 8'h00);

        // R11 write flag in edge mode
        @(negedge clk); idle(); bit_wr = 1; bit_addr = 8'h89; bit_val = 1; tick("R11");
        chk("R11 edge write", {7'b0, xreq[0]}, 8'h01);

        // R9 level mode
        @(negedge clk); idle(); bit_wr = 1; bit_addr = 8'h88; bit_val = 0; tick("R9");
        chk("R9 level low", {7'b0, xreq[0]}, 8'h01);
        @(negedge clk); idle(); xack = 2'b01; tick("R9");
        chk("R9 ack ignored", {7'b0, xreq[0]}, 8'h01);
        @(negedge clk); idle(); xpin_n = 2'b11; #1;
        chk("R9 same cycle follow", {7'b0, xreq[0]}, 8'h00);
        chk("R10 live read", sfr_rdata, exp_reg());
        tick("R9");
        @(negedge clk); idle(); bit_wr = 1; bit_addr = 8'h89; bit_val = 1; tick("R11");
        chk("R11 level write hidden", {7'b0, xreq[0]}, 8'h00);
        @(negedge clk); idle(); bit_wr = 1; bit_addr = 8'h88; bit_val = 1; tick("R11");
        chk("R11 edge starts clear", {7'b0, xreq[0]}, 8'h00);

        // R8 edge with ack together: set wins
        @(negedge clk); idle(); xpin_n = 2'b10; xack = 2'b01; tick("R8");
        chk("R8 edge beats ack", {7'b0, xreq[0]}, 8'h01);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); idle();
            if ($urandom_range(7) == 0) begin
                sfr_wr = 1; sfr_wdata = 8'($urandom);
                sfr_addr = ($urandom_range(3) == 0) ? 8'($urandom) : RA;
            end
            if ($urandom_range(5) == 0) begin
                bit_wr = 1; bit_val = 1'($urandom);
                bit_addr = ($urandom_range(4) == 0) ? 8'($urandom) : (RA + 8'($urandom_range(7)));
            end
            if ($urandom_range(5) == 0) sfr_addr = 8'($urandom);
            tmr_ovf = ($urandom_range(4) == 0) ? 2'($urandom) : 2'b00;
            tmr_ack = ($urandom_range(3) == 0) ? 2'($urandom) : 2'b00;
            xack    = ($urandom_range(3) == 0) ? 2'($urandom) : 2'b00;
            if ($urandom_range(5) == 0) xpin_n = xpin_n ^ 2'($urandom);
            tick("R10");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule